// File: doc/BRIEF.md
# Eight-Channel DAC Code Register Bank

This block sits behind a serial receiver and in front of eight converter channels. Each accepted 16-bit command word carries a 4-bit address in its top nibble and a 12-bit data field below it. The address selects one of eight channel holding registers, one of four channel pairs, a preset register, or one of two control registers. A pair write loads the first channel of the pair with the data and the second with its bitwise inverse.

The holding registers feed a second rank of output latches, and the latches drive the code buses. An active-low load input moves the holding values into the latches on every clock while it is low. Tied low, it makes each write reach its output one clock after the write is captured. Pulsed low, it updates all eight channels together. An active-low preset input overrides every code bus with the preset register, without waiting for a clock and without disturbing the latches. The control registers supply a global power-down, a daisy-chain enable, a two's-complement input mode, and power-down and speed flags for each pair. A parameter sets the resolution to 12, 10 or 8 bits. At the lower resolutions the unused low data bits are stored as zero.

Top module: `dac_regbank`

## Requirements
- R1: Address values 0 to 7 write the holding register of channel 0 (A) to 7 (H). Channel i drives `chCode[12*i+11 : 12*i]`.
- R2: Address values 12, 13, 14 and 15 write the pairs A/B, C/D, E/F and G/H. The lower-numbered channel of the pair receives the converted data and the higher-numbered one receives its bitwise inverse.
- R3: Address 8 writes control register 0. Data bit 4 drives `globalPowerDown`, bit 3 drives `chainEnable`, and bit 0 drives `twosComp`, where 1 selects two's-complement input.
- R4: Address 9 writes control register 1. Data bits 7:4 drive `pairPowerDown[3:0]` and bits 3:0 drive `pairFast[3:0]`. Index 3 is pair GH, index 2 is EF, index 1 is CD and index 0 is AB. A speed flag of 1 means fast.
- R5: A command to address 11 changes no register and no output.
- R6: While `loadN` is high, the output latches hold their values whatever is written to the holding registers.
- R7: While `loadN` is low, each clock edge copies the holding registers into the latches. A write captured at one edge therefore appears on its code bus after the following edge.
- R8: While `presetN` is low, every code bus shows the preset register (address 10) without waiting for a clock. When `presetN` returns high, the code buses show the unchanged latch contents again.
- R9: When `twosComp` is 1, bit 11 of the data field is inverted before it is stored in a channel or preset register.
- R10: With `RES_BITS` set to 10, stored data bits 1:0 are zero. With `RES_BITS` set to 8, stored data bits 3:0 are zero.
- R11: Reset clears every holding register, latch, preset and control register, so all outputs read zero.
- R12: A word presented while `cmdValid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Qualifies cmdWord for one cycle |
| cmdWord | input | 16 | Address [15:12] and data [11:0] |
| loadN | input | 1 | Active-low load, level sensitive |
| presetN | input | 1 | Active-low preset override |
| chCode | output | 96 | Eight 12-bit channel codes, channel A in the low bits |
| pairPowerDown | output | 4 | Per-pair power-down, index 0 is AB |
| pairFast | output | 4 | Per-pair fast settling, index 0 is AB |
| globalPowerDown | output | 1 | Whole-device power-down |
| chainEnable | output | 1 | Daisy-chain output enable |
| twosComp | output | 1 | Two's-complement input mode active |

## Verification
On every cycle the assertions check four things. First, the latches stay frozen while the load input is high and follow the holding registers while it is low. Second, the second channel of a pair is the masked inverse of the first after a pair write. Third, ignored low bits are always zero and the preset override fully replaces every code bus. Fourth, idle cycles and the reserved address leave the control registers untouched. Only the bench scenarios can show the exact address-to-channel mapping, the bit positions of the control fields, the MSB inversion in two's-complement mode, and the cycle at which a write reaches its output. The same applies to the restoration of the latch values after a preset, and to resolution masking at each resolution setting.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam int NUM_CH  = 8;
  localparam int DATA_W  = 12;
  localparam int ADDR_W  = 4;
  localparam int WORD_W  = ADDR_W + DATA_W;
  localparam int NUM_PAIR = NUM_CH / 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL0    = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1    = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_PRESET   = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_RESERVED = 4'd11;

  typedef struct packed {
    logic [NUM_CH-1:0] holdWe;
    logic [NUM_CH-1:0] holdInv;
    logic              presetWe;
  } strobe_t;
endpackage

// File: rtl/dac_regbank_ctrl.sv
module dac_regbank_ctrl
  import dac_regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [WORD_W-1:0]   cmdWord,
  output strobe_t             strobe,
  output logic [DATA_W-1:0]   dataField,
  output logic [NUM_PAIR-1:0] pairPowerDown,
  output logic [NUM_PAIR-1:0] pairFast,
  output logic                globalPowerDown,
  output logic                chainEnable,
  output logic                twosComp
);
  logic [ADDR_W-1:0] addr;
  logic              ctrl0We;
  logic              ctrl1We;
  logic [2:0]        ctrl0Reg;
  logic [2*NUM_PAIR-1:0] ctrl1Reg;

  assign addr      = cmdWord[WORD_W-1:DATA_W];
  assign dataField = cmdWord[DATA_W-1:0];

  always_comb begin
    strobe  = '0;
    ctrl0We = 1'b0;
    ctrl1We = 1'b0;
    if (cmdValid) begin
      if (addr < ADDR_W'(NUM_CH)) begin
        strobe.holdWe[addr[2:0]] = 1'b1;
      end else if (addr == ADDR_CTRL0) begin
        ctrl0We = 1'b1;
      end else if (addr == ADDR_CTRL1) begin
        ctrl1We = 1'b1;
      end else if (addr == ADDR_PRESET) begin
        strobe.presetWe = 1'b1;
      end else if (addr != ADDR_RESERVED) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if ((i / 2) == int'(addr[1:0])) begin
            strobe.holdWe[i]  = 1'b1;
            strobe.holdInv[i] = (i % 2) == 1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl0Reg <= '0;
      ctrl1Reg <= '0;
    end else begin
      if (ctrl0We) ctrl0Reg <= {dataField[4], dataField[3], dataField[0]};
      if (ctrl1We) ctrl1Reg <= dataField[2*NUM_PAIR-1:0];
    end
  end

  assign globalPowerDown = ctrl0Reg[2];
  assign chainEnable     = ctrl0Reg[1];
  assign twosComp        = ctrl0Reg[0];
  assign pairPowerDown   = ctrl1Reg[2*NUM_PAIR-1:NUM_PAIR];
  assign pairFast        = ctrl1Reg[NUM_PAIR-1:0];

  // R5: reserved address leaves control state alone
  p_reserved_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && addr == ADDR_RESERVED) |=> ($stable(ctrl0Reg) && $stable(ctrl1Reg)))
    else $error("reserved address changed control state");

  // R12: idle cycles leave control state alone
  p_idle_ctrl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ($stable(ctrl0Reg) && $stable(ctrl1Reg)))
    else $error("control changed without command");

  // R2: a pair write always strobes exactly two channels
  p_pair_two_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && addr >= 4'd12) |-> ($countones(strobe.holdWe) == 2 && $countones(strobe.holdInv) == 1))
    else $error("pair strobe malformed");
endmodule

// File: rtl/dac_regbank_dp.sv
module dac_regbank_dp
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  input  logic [DATA_W-1:0]             dataField,
  input  logic                          twosComp,
  input  logic                          loadN,
  input  logic                          presetN,
  output logic [NUM_CH-1:0][DATA_W-1:0] codeOut
);
  localparam int DROP_BITS = DATA_W - RES_BITS;
  localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << DROP_BITS;

  logic [DATA_W-1:0]             convData;
  logic [DATA_W-1:0]             keptData;
  logic [DATA_W-1:0]             invData;
  logic [DATA_W-1:0]             presetReg;
  logic [NUM_CH-1:0][DATA_W-1:0] holdReg;
  logic [NUM_CH-1:0][DATA_W-1:0] outLatch;

  // Two's-complement to offset binary: flip the sign bit only.
  assign convData = dataField ^ {twosComp, {(DATA_W-1){1'b0}}};
  assign keptData = convData & KEEP_MASK;
  assign invData  = ~convData & KEEP_MASK;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   holdReg[ch] <= '0;
      else if (strobe.holdWe[ch])  holdReg[ch] <= strobe.holdInv[ch] ? invData : keptData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               presetReg <= '0;
    else if (strobe.presetWe) presetReg <= keptData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      outLatch <= '0;
    else if (!loadN) outLatch <= holdReg;
  end

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      codeOut[ch] = presetN ? outLatch[ch] : presetReg;
    end
  end

  // R6: latches frozen while load is released
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> $stable(outLatch))
    else $error("latch moved with load high");

  // R7: latches follow holding registers while load is asserted
  p_latch_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (outLatch == $past(holdReg)))
    else $error("latch did not follow holding");

  // R8: preset replaces every code bus
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_preset_chk
    p_preset_force_r8: assert property (@(posedge clk) disable iff (!rstN)
      !presetN |-> (codeOut[ch] == presetReg))
      else $error("preset override incomplete");
  end

  // R10: dropped low bits stay zero everywhere
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mask_chk
    p_low_bits_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
      ((holdReg[ch] & ~KEEP_MASK) == '0) && ((outLatch[ch] & ~KEEP_MASK) == '0))
      else $error("ignored bits stored");
  end

  // R2: the odd channel of a pair ends up as the masked inverse of the even one
  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair_chk
    p_pair_inverse_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.holdWe[2*p+1] && strobe.holdInv[2*p+1]) |=>
        (holdReg[2*p+1] == (~holdReg[2*p] & KEEP_MASK)))
      else $error("pair complement wrong");
  end

  // R12: no strobe, no holding change
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdWe == '0 && !strobe.presetWe) |=> ($stable(holdReg) && $stable(presetReg)))
    else $error("holding changed without strobe");
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [15:0]              cmdWord,
  input  logic                     loadN,
  input  logic                     presetN,
  output logic [NUM_CH*DATA_W-1:0] chCode,
  output logic [NUM_PAIR-1:0]      pairPowerDown,
  output logic [NUM_PAIR-1:0]      pairFast,
  output logic                     globalPowerDown,
  output logic                     chainEnable,
  output logic                     twosComp
);
  strobe_t                       strobe;
  logic [DATA_W-1:0]             dataField;
  logic [NUM_CH-1:0][DATA_W-1:0] codeOut;

  initial begin
    assert (RES_BITS == 12 || RES_BITS == 10 || RES_BITS == 8)
      else $error("RES_BITS must be 12, 10 or 8");
  end

  dac_regbank_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cmdValid       (cmdValid),
    .cmdWord        (cmdWord),
    .strobe         (strobe),
    .dataField      (dataField),
    .pairPowerDown  (pairPowerDown),
    .pairFast       (pairFast),
    .globalPowerDown(globalPowerDown),
    .chainEnable    (chainEnable),
    .twosComp       (twosComp)
  );

  dac_regbank_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataField(dataField),
    .twosComp (twosComp),
    .loadN    (loadN),
    .presetN  (presetN),
    .codeOut  (codeOut)
  );

  assign chCode = codeOut;
endmodule

// File: tb/dac_regbank_bench.sv
module dac_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic        loadN = 1'b0;
  logic        presetN = 1'b1;
  logic [95:0] chCode, chCode10, chCode8;
  logic [3:0]  pairPowerDown, pairFast, pd10, pf10, pd8, pf8;
  logic        globalPowerDown, chainEnable, twosComp;
  logic        g10, c10, t10, g8, c8, t8;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_regbank u_dac_regbank (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .loadN(loadN), .presetN(presetN), .chCode(chCode),
    .pairPowerDown(pairPowerDown), .pairFast(pairFast),
    .globalPowerDown(globalPowerDown), .chainEnable(chainEnable), .twosComp(twosComp));

  dac_regbank #(.RES_BITS(10)) u_res10 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .loadN(loadN), .presetN(presetN), .chCode(chCode10),
    .pairPowerDown(pd10), .pairFast(pf10),
    .globalPowerDown(g10), .chainEnable(c10), .twosComp(t10));

  dac_regbank #(.RES_BITS(8)) u_res8 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .loadN(loadN), .presetN(presetN), .chCode(chCode8),
    .pairPowerDown(pd8), .pairFast(pf8),
    .globalPowerDown(g8), .chainEnable(c8), .twosComp(t8));

  typedef struct packed {
    logic [15:0] word;
    logic [2:0]  ch;
    logic [11:0] code;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h0123, 3'd0, 12'h123},
    '{16'h1FFF, 3'd1, 12'hFFF},
    '{16'h2000, 3'd2, 12'h000},
    '{16'h3800, 3'd3, 12'h800},
    '{16'h4ABC, 3'd4, 12'hABC},
    '{16'h57FF, 3'd5, 12'h7FF},
    '{16'h6001, 3'd6, 12'h001},
    '{16'h7FFE, 3'd7, 12'hFFE},
    '{16'hC321, 3'd0, 12'h321},
    '{16'hF0F0, 3'd6, 12'h0F0}
  };

  function automatic logic [11:0] chanOf(logic [95:0] bus, int ch);
    return bus[ch*12 +: 12];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeWord(logic [15:0] w);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = w;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 codes", chCode, 96'h0);
    check("R11 flags", {pairPowerDown, pairFast, globalPowerDown, chainEnable, twosComp}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R7: table of direct and pair writes with load held low
    for (int i = 0; i < NV; i++) begin
      writeWord(VECS[i].word);
      @(negedge clk);
      check("R1 table", chanOf(chCode, int'(VECS[i].ch)), VECS[i].code);
    end
    // R2: complements from the table pair writes
    check("R2 pair AB second", chanOf(chCode, 1), 12'hCDE);
    check("R2 pair GH second", chanOf(chCode, 7), 12'hF0F);

    writeWord(16'hD5A5);
    @(negedge clk);
    check("R2 pair CD first", chanOf(chCode, 2), 12'h5A5);
    check("R2 pair CD second", chanOf(chCode, 3), 12'hA5A);

    // R4: control register 1
    writeWord(16'h90A5);
    check("R4 power-down", pairPowerDown, 4'b1010);
    check("R4 speed", pairFast, 4'b0101);

    // R3: control register 0
    writeWord(16'h8019);
    check("R3 ctrl0 fields", {globalPowerDown, chainEnable, twosComp}, 3'b111);

    // R9: two's complement flips bit 11
    writeWord(16'h0123);
    @(negedge clk);
    check("R9 msb flipped", chanOf(chCode, 0), 12'h923);
    writeWord(16'h8000);
    check("R3 ctrl0 cleared", {globalPowerDown, chainEnable, twosComp}, 3'b000);

    // R5: reserved address
    writeWord(16'hBFFF);
    @(negedge clk);
    check("R5 codes", chanOf(chCode, 0), 12'h923);
    check("R5 flags", {pairPowerDown, pairFast, globalPowerDown, chainEnable, twosComp}, 11'b1010_0101_000);

    // R12: word without valid
    @(negedge clk);
    cmdWord = 16'h0FFF;
    @(negedge clk);
    @(negedge clk);
    check("R12 no valid", chanOf(chCode, 0), 12'h923);

    // R6: load held high freezes outputs
    loadN = 1'b1;
    writeWord(16'h0777);
    repeat (2) @(negedge clk);
    check("R6 frozen", chanOf(chCode, 0), 12'h923);
    loadN = 1'b0;
    @(negedge clk);
    loadN = 1'b1;
    check("R6 after pulse", chanOf(chCode, 0), 12'h777);
    loadN = 1'b0;

    // R7: one-edge lag from holding to latch
    writeWord(16'h1456);
    check("R7 not yet", chanOf(chCode, 1), 12'hCDE);
    @(negedge clk);
    check("R7 updated", chanOf(chCode, 1), 12'h456);

    // R8: preset override
    writeWord(16'hA3C3);
    presetN = 1'b0;
    #1;
    check("R8 forced", chCode, {8{12'h3C3}});
    presetN = 1'b1;
    #1;
    check("R8 restored A", chanOf(chCode, 0), 12'h777);
    check("R8 restored B", chanOf(chCode, 1), 12'h456);

    // R10: resolution masking
    writeWord(16'h2ABF);
    @(negedge clk);
    check("R10 full res", chanOf(chCode, 2), 12'hABF);
    check("R10 ten bit", chanOf(chCode10, 2), 12'hABC);
    check("R10 eight bit", chanOf(chCode8, 2), 12'hAB0);

    // R11: reset mid-run
    rstN = 1'b0;
    #1;
    check("R11 cleared", chCode, 96'h0);
    check("R11 flags cleared", {pairPowerDown, pairFast}, 8'h0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule